// File: doc/BRIEF.md
# Serial Clock Frequency Failure Monitor

This block supervises an external high-rate serial clock by measuring it against the local system clock. The external clock drives a divide-by-32 counter whose window boundary is carried into the system clock domain through a toggle synchronizer. In the system domain, an 8-bit counter counts prescaled system clock ticks during each window. When a window completes, the count is latched into a readable register, and the tick counter restarts.

Two bounds define the range the clock may occupy. A window count below the lower bound indicates a clock that runs too fast. A running count above the upper bound indicates a clock that runs too slow or has stopped. The upper bound is checked on every system cycle, so a dead external clock is still caught even though no further windows complete.

Either fault sets a sticky failure flag. The flag drives an interrupt line. When enabled, it also raises a request to switch to an internal serial clock. Software clears the flag with a one-cycle clear pulse.

Top module: `srclk_watch`

## Requirements
- R1: Each window spans 32 rising edges of `ext_clk`. `tick_count` holds the number of prescaled system ticks counted in the last completed window. The count may deviate by at most two from the ideal ratio, because of synchronization.
- R2: `tick_count` updates only when a window completes. While `ext_clk` is stopped, it keeps its value.
- R3: `div_sel` = N with N from 0 to 8 divides the system clock by 2^N. The values 9 to 15 divide by 256.
- R4: The flag is set when a completed window count is strictly less than `lo_bound`. The comparison is unsigned.
- R5: The flag is set on any system cycle in which the running tick count is strictly greater than `hi_bound`. The comparison is unsigned. This catches a stopped `ext_clk`.
- R6: The running tick counter saturates at 255 and does not wrap.
- R7: `fail_flag` is sticky. A one-cycle pulse on `fail_clr` clears it. If a fault is present in the same cycle, the fault wins and the flag stays set.
- R8: `fail_irq` equals `fail_flag`.
- R9: `switch_req` is 1 exactly when `fail_flag` is 1 and `switch_en` is 1.
- R10: After reset, `tick_count` is 0, `fail_flag` is 0, `fail_irq` is 0 and `switch_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Local system clock |
| sys_rst | input | 1 | Synchronous active-high reset, system domain |
| ext_clk | input | 1 | External high-rate serial clock being monitored |
| ext_rst | input | 1 | Synchronous active-high reset, external domain |
| div_sel | input | 4 | Prescaler select: divide by 2^N, with N capped at 8 |
| lo_bound | input | 8 | Minimum allowed window count |
| hi_bound | input | 8 | Maximum allowed running count |
| switch_en | input | 1 | Enables the internal-clock switch request |
| fail_clr | input | 1 | One-cycle pulse that clears the failure flag |
| tick_count | output | 8 | Tick count latched at the end of the last window |
| fail_flag | output | 1 | Sticky clock failure status |
| fail_irq | output | 1 | Interrupt line driven by the failure flag |
| switch_req | output | 1 | Request to switch to the internal serial clock |

## Verification
The monitor runs with a steady external clock at a known ratio, and the latched count is compared with that ratio at three prescaler settings. Divide-by-1 and divide-by-4 show that the count scales with the prescaler. Selects 8 and 15 must produce the same count, which shows that the prescaler saturates above 8. Bounds are then placed above the measured count, below it, and around it. These cases separate the window-end lower-bound fault from the continuous upper-bound fault and from fault-free operation. Finally, the external clock is halted, with a clear pulse issued long after the counter would have wrapped. This shows that the fault persists, the counter saturates, and the latched count stays frozen.

// File: rtl/srclk_pkg.sv
package srclk_pkg;
    localparam int CNT_W    = 8;
    localparam int SEL_W    = 4;
    localparam int WIN_LOG2 = 5;
    localparam int MAX_EXP  = CNT_W;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic too_fast;
        logic too_slow;
    } fault_t;

    function automatic cnt_t div_mask(input logic [SEL_W-1:0] sel);
        cnt_t m;
        if (int'(sel) >= MAX_EXP) m = '1;
        else                      m = cnt_t'((9'd1 << sel) - 9'd1);
        return m;
    endfunction
endpackage

// File: rtl/srclk_window_div.sv
module srclk_window_div #(
    parameter int WIN_LOG2 = srclk_pkg::WIN_LOG2
) (
    input  logic ext_clk,
    input  logic ext_rst,
    output logic win_toggle
);
    logic [WIN_LOG2-1:0] edge_cnt;

    always_ff @(posedge ext_clk) begin
        if (ext_rst) begin
            edge_cnt   <= '0;
            win_toggle <= 1'b0;
        end else begin
            edge_cnt <= edge_cnt + 1'b1;
            if (&edge_cnt) win_toggle <= ~win_toggle;
        end
    end
endmodule

// File: rtl/srclk_sync.sv
module srclk_sync (
    input  logic sys_clk,
    input  logic sys_rst,
    input  logic toggle_in,
    output logic win_pulse
);
    logic [2:0] stage;

    always_ff @(posedge sys_clk) begin
        if (sys_rst) stage <= '0;
        else         stage <= {stage[1:0], toggle_in};
    end

    assign win_pulse = stage[2] ^ stage[1];

    // R1: a window boundary produces a single-cycle pulse
    a_r1_single_pulse: assert property (@(posedge sys_clk) disable iff (sys_rst)
        win_pulse |=> !win_pulse);
endmodule

// File: rtl/srclk_prescale.sv
module srclk_prescale
    import srclk_pkg::*;
(
    input  logic             sys_clk,
    input  logic             sys_rst,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick
);
    cnt_t pre_cnt;
    cnt_t mask;

    always_ff @(posedge sys_clk) begin
        if (sys_rst) pre_cnt <= '0;
        else         pre_cnt <= pre_cnt + 1'b1;
    end

    assign mask = div_mask(div_sel);
    assign tick = (pre_cnt & mask) == mask;

    // R3: a select of zero yields a tick on every cycle
    a_r3_div_one: assert property (@(posedge sys_clk) disable iff (sys_rst)
        (div_sel == '0) |-> tick);
endmodule

// File: rtl/srclk_counter.sv
module srclk_counter
    import srclk_pkg::*;
(
    input  logic sys_clk,
    input  logic sys_rst,
    input  logic tick,
    input  logic win_pulse,
    output cnt_t run_cnt,
    output cnt_t latched
);
    always_ff @(posedge sys_clk) begin
        if (sys_rst) begin
            run_cnt <= '0;
            latched <= '0;
        end else if (win_pulse) begin
            run_cnt <= '0;
            latched <= run_cnt;
        end else if (tick && run_cnt != '1) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    // R2: the latched value is the running count from the end of the window
    a_r2_latch: assert property (@(posedge sys_clk) disable iff (sys_rst)
        win_pulse |=> (latched == $past(run_cnt)) && (run_cnt == '0));
    // R2: with no window boundary the latched value holds
    a_r2_hold: assert property (@(posedge sys_clk) disable iff (sys_rst)
        !win_pulse |=> $stable(latched));
    // R6: the counter saturates and does not wrap
    a_r6_saturate: assert property (@(posedge sys_clk) disable iff (sys_rst)
        (run_cnt == '1 && !win_pulse) |=> run_cnt == '1);
endmodule

// File: rtl/srclk_watch.sv
module srclk_watch
    import srclk_pkg::*;
(
    input  logic             sys_clk,
    input  logic             sys_rst,
    input  logic             ext_clk,
    input  logic             ext_rst,
    input  logic [SEL_W-1:0] div_sel,
    input  logic [CNT_W-1:0] lo_bound,
    input  logic [CNT_W-1:0] hi_bound,
    input  logic             switch_en,
    input  logic             fail_clr,
    output logic [CNT_W-1:0] tick_count,
    output logic             fail_flag,
    output logic             fail_irq,
    output logic             switch_req
);
    logic   win_toggle;
    logic   win_pulse;
    logic   tick;
    cnt_t   run_cnt;
    fault_t fault;

    srclk_window_div #(.WIN_LOG2(WIN_LOG2)) u_div (
        .ext_clk    (ext_clk),
        .ext_rst    (ext_rst),
        .win_toggle (win_toggle)
    );

    srclk_sync u_sync (
        .sys_clk   (sys_clk),
        .sys_rst   (sys_rst),
        .toggle_in (win_toggle),
        .win_pulse (win_pulse)
    );

    srclk_prescale u_pre (
        .sys_clk (sys_clk),
        .sys_rst (sys_rst),
        .div_sel (div_sel),
        .tick    (tick)
    );

    srclk_counter u_cnt (
        .sys_clk   (sys_clk),
        .sys_rst   (sys_rst),
        .tick      (tick),
        .win_pulse (win_pulse),
        .run_cnt   (run_cnt),
        .latched   (tick_count)
    );

    always_comb begin
        fault.too_fast = win_pulse && (run_cnt < lo_bound);
        fault.too_slow = run_cnt > hi_bound;
    end

    always_ff @(posedge sys_clk) begin
        if (sys_rst)                          fail_flag <= 1'b0;
        else if (fault.too_fast || fault.too_slow) fail_flag <= 1'b1;
        else if (fail_clr)                    fail_flag <= 1'b0;
    end

    assign fail_irq   = fail_flag;
    assign switch_req = fail_flag & switch_en;

    // R7: flag stays set without a clear pulse
    a_r7_sticky: assert property (@(posedge sys_clk) disable iff (sys_rst)
        (fail_flag && !fail_clr) |=> fail_flag);
    // R5: running count above the upper bound sets the flag
    a_r5_over_max: assert property (@(posedge sys_clk) disable iff (sys_rst)
        (run_cnt > hi_bound) |=> fail_flag);
    // R4: short window sets the flag
    a_r4_under_min: assert property (@(posedge sys_clk) disable iff (sys_rst)
        (win_pulse && (run_cnt < lo_bound)) |=> fail_flag);
    // R7: a flag only rises on a fault
    a_r7_rise_cause: assert property (@(posedge sys_clk) disable iff (sys_rst)
        $rose(fail_flag) |-> $past(fault.too_fast || fault.too_slow));
endmodule

// File: tb/sim_srclk_watch.sv
`timescale 1ns/1ps
module sim_srclk_watch;
    logic       sys_clk = 1'b0;
    logic       sys_rst = 1'b1;
    logic       ext_clk = 1'b0;
    logic       ext_rst = 1'b1;
    logic [3:0] div_sel = 4'd0;
    logic [7:0] lo_bound = 8'd0;
    logic [7:0] hi_bound = 8'd255;
    logic       switch_en = 1'b0;
    logic       fail_clr = 1'b0;
    logic [7:0] tick_count;
    logic       fail_flag, fail_irq, switch_req;

    bit  ext_run = 1'b1;
    real ext_half = 10.0;
    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #2 sys_clk = ~sys_clk;
    always begin
        #(ext_half);
        if (ext_run) ext_clk = ~ext_clk;
    end

    srclk_watch u0 (
        .sys_clk(sys_clk), .sys_rst(sys_rst), .ext_clk(ext_clk), .ext_rst(ext_rst),
        .div_sel(div_sel), .lo_bound(lo_bound), .hi_bound(hi_bound),
        .switch_en(switch_en), .fail_clr(fail_clr), .tick_count(tick_count),
        .fail_flag(fail_flag), .fail_irq(fail_irq), .switch_req(switch_req)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge sys_clk);
    endtask

    task automatic clear_flag();
        fail_clr = 1'b1;
        cycles(1);
        fail_clr = 1'b0;
        cycles(1);
    endtask

    task automatic test_reset();
        cycles(1);
        check(tick_count == 0, "R10 count", tick_count, 0);
        check(fail_flag == 0, "R10 flag", fail_flag, 0);
        check(fail_irq == 0, "R10 irq", fail_irq, 0);
        check(switch_req == 0, "R10 switch", switch_req, 0);
    endtask

    // R1 R3: count tracks the clock ratio under the selected division
    task automatic test_ratio(input int sel, input real half, input int win_cyc,
                              input int lo, input int hi, input string req);
        div_sel = 4'(sel);
        ext_half = half;
        cycles(3 * win_cyc);
        check(tick_count >= lo && tick_count <= hi, req, tick_count, (lo + hi) / 2);
    endtask

    // R4 R5 R7 R8 R9: bounds around a window count of about 159
    task automatic test_bounds();
        div_sel = 4'd0; ext_half = 10.0;
        lo_bound = 8'd150; hi_bound = 8'd170;
        cycles(400); clear_flag(); cycles(500);
        check(fail_flag == 0, "R4 R5 in range no fault", fail_flag, 0);
        lo_bound = 8'd200; hi_bound = 8'd255;
        cycles(400);
        check(fail_flag == 1, "R4 below minimum", fail_flag, 1);
        check(fail_irq == 1, "R8 irq follows", fail_irq, 1);
        check(switch_req == 0, "R9 switch disabled", switch_req, 0);
        switch_en = 1'b1; cycles(1);
        check(switch_req == 1, "R9 switch enabled", switch_req, 1);
        switch_en = 1'b0;
        lo_bound = 8'd150; hi_bound = 8'd170;
        cycles(500);
        check(fail_flag == 1, "R7 sticky", fail_flag, 1);
        clear_flag(); cycles(500);
        check(fail_flag == 0, "R7 cleared", fail_flag, 0);
        lo_bound = 8'd0; hi_bound = 8'd100;
        cycles(200);
        check(fail_flag == 1, "R5 above maximum", fail_flag, 1);
        hi_bound = 8'd255; clear_flag(); cycles(400);
        check(fail_flag == 0, "R5 clear after", fail_flag, 0);
    endtask

    // R2 R5 R6 R7: stopped external clock
    task automatic test_stop();
        int held;
        hi_bound = 8'd200; lo_bound = 8'd0;
        cycles(400); clear_flag();
        held = tick_count;
        ext_run = 1'b0;
        cycles(250);
        check(fail_flag == 1, "R5 stopped clock", fail_flag, 1);
        cycles(500);
        clear_flag();
        check(fail_flag == 1, "R6 R7 saturated fault persists", fail_flag, 1);
        check(tick_count == held, "R2 count frozen", tick_count, held);
        ext_run = 1'b1;
    endtask

    initial begin
        #700000;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        cycles(20);
        sys_rst = 1'b0; ext_rst = 1'b0;
        test_reset();
        test_ratio(0, 10.0, 160, 157, 161, "R1 div1 count");
        test_ratio(2, 10.0, 160, 38, 42, "R3 div4 count");
        test_ratio(8, 500.0, 8000, 29, 33, "R3 div256 count");
        test_ratio(15, 500.0, 8000, 29, 33, "R3 select above 8 caps");
        test_bounds();
        test_stop();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule